// File: doc/BRIEF.md
# Flash Program and Erase Command Sequencer

This block sits between a 32-bit register bus and a simple flash-array port. Software loads a target address, up to four 32-bit data words and a clock-divide value, then writes the control register to start one of three operations: a program of one or four words, an erase of the page that holds the address, or an erase of the whole array. While an operation runs, the block holds a command code, the address, the data and a lane mask steady on the array port. It counts operation ticks from a prescaler until the time set for that command has passed.

Every command is guarded. The four-bit key field in the control word must hold the open value. Each erase also needs its own eight-bit confirmation code. A command that fails either check, names more than one operation, or arrives while another is running changes nothing on the array port. It only raises an access-fail flag. Completion raises a done flag. Each flag has its own enable, and both flags drive one interrupt line.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, every register reads zero except the divide register, which reads DIV_RESET. The array command is idle (0) and `irq` is low.
- R2: The address (offset 0x00, 32 bits), the divide value (0x04, 8 bits, upper bits read 0) and the data words (0x30, 0x34, 0x38, 0x3C) read back what was written. The control register (0x08) keeps key [31:28], burst [27], low-voltage [25], erase code [15:8] and width [4]. Its other bits read 0 when idle. Unmapped offsets read 0.
- R3: A control write with bit 0 set and key 0x2 starts a program. Control bits 0 and 24 then read 1 for exactly WR_TICKS ticks. A tick comes every max(divide,1) clock cycles, counted from the start. At the end both bits clear and the done flag (interrupt register bit 0) sets.
- R4: Bit 2 with erase code 0x55 starts a page erase that lasts PAGE_TICKS ticks. Bit 1 with code 0xAA starts a mass erase that lasts MASS_TICKS ticks. The same key rule applies to both.
- R5: Any of the following leaves the array idle and sets the access-fail flag (interrupt register bit 1): a key other than 0x2, an erase code that does not match its command, or more than one of bits [2:0] set.
- R6: A control write that sets any of bits [2:0] while an operation runs is ignored completely. It sets access-fail, and the running operation keeps its command and its length.
- R7: The array command `fa_cmd` is 0 when idle, 1 for a program, 2 for a page erase and 3 for a mass erase. `fa_addr` and `fa_wdata` show the address register and the data words (word 0 in the low bits). For a program, `fa_wmask` is 4'hF in 128-bit mode (width 0). In 32-bit mode it is one-hot on address bits [3:2]. It is 0 otherwise.
- R8: Writing 1 to interrupt bit 0 or bit 1 clears that flag. Writing 0 leaves it as it is.
- R9: Interrupt bits 8 and 9 enable the done and access-fail flags. `irq` is high exactly when an enabled flag is set.
- R10: A divide value of 0 times operations like a value of 1.
- R11: While an operation runs, writes to the address, divide, data and control registers are ignored. The interrupt register stays writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| fa_cmd | output | 2 | Array command: 0 idle, 1 program, 2 page erase, 3 mass erase |
| fa_addr | output | 32 | Target address |
| fa_wdata | output | 128 | Program data, word 0 in the low bits |
| fa_wmask | output | 4 | Word lanes written by a program |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that `reg_we` and `reg_addr` are always known. They also assume the control register is the only way a command starts. A fail flag raised by a bad key is therefore checked against the write that carried it, one cycle later. The bench changes inputs only at falling edges and uses word-aligned offsets. Its random commands are built from legal and illegal keys, codes and command bits. Each command runs to completion before the next one starts, except in the directed case that issues a command while an operation is busy.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 4;
    localparam int LANE_W    = $clog2(NUM_WORDS);

    localparam logic [7:0] OFF_ADDR  = 8'h00;
    localparam logic [7:0] OFF_DIV   = 8'h04;
    localparam logic [7:0] OFF_CTL   = 8'h08;
    localparam logic [7:0] OFF_IRQ   = 8'h24;
    localparam logic [7:0] OFF_DATA0 = 8'h30;

    localparam logic [3:0] KEY_OPEN  = 4'h2;
    localparam logic [3:0] KEY_SHUT  = 4'h3;
    localparam logic [7:0] CODE_PAGE = 8'h55;
    localparam logic [7:0] CODE_MASS = 8'hAA;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PROG = 2'd1,
        OP_PAGE = 2'd2,
        OP_MASS = 2'd3
    } fa_op_e;

    // Stored control settings (command bits live in the sequencer state)
    typedef struct packed {
        logic [3:0] key;
        logic       burst;
        logic       lowv;
        logic [7:0] code;
        logic       narrow;
    } ctl_cfg_t;

    // Decoded command request carried by one control write
    typedef struct packed {
        logic   req;
        logic   legal;
        fa_op_e op;
    } cmd_req_t;

    function automatic ctl_cfg_t cfg_from_word(input logic [31:0] w);
        ctl_cfg_t c;
        c.key    = w[31:28];
        c.burst  = w[27];
        c.lowv   = w[25];
        c.code   = w[15:8];
        c.narrow = w[4];
        return c;
    endfunction

    function automatic logic [31:0] ctl_word(input ctl_cfg_t c, input fa_op_e op);
        logic [31:0] w;
        w        = '0;
        w[31:28] = c.key;
        w[27]    = c.burst;
        w[25]    = c.lowv;
        w[24]    = (op != OP_IDLE);
        w[15:8]  = c.code;
        w[4]     = c.narrow;
        w[2]     = (op == OP_PAGE);
        w[1]     = (op == OP_MASS);
        w[0]     = (op == OP_PROG);
        return w;
    endfunction

    function automatic cmd_req_t judge_cmd(input logic [31:0] w);
        cmd_req_t r;
        logic     key_ok;
        key_ok  = (w[31:28] == KEY_OPEN);
        r.req   = |w[2:0];
        r.op    = OP_IDLE;
        r.legal = 1'b0;
        case (w[2:0])
            3'b001: begin r.op = OP_PROG; r.legal = key_ok; end
            3'b010: begin r.op = OP_MASS; r.legal = key_ok && (w[15:8] == CODE_MASS); end
            3'b100: begin r.op = OP_PAGE; r.legal = key_ok && (w[15:8] == CODE_PAGE); end
            default: begin r.op = OP_IDLE; r.legal = 1'b0; end
        endcase
        return r;
    endfunction

    function automatic logic [NUM_WORDS-1:0] lane_mask(input logic narrow,
                                                       input logic [LANE_W-1:0] sel);
        logic [NUM_WORDS-1:0] m;
        if (narrow) m = NUM_WORDS'(1) << sel;
        else        m = '1;
        return m;
    endfunction

endpackage

// File: rtl/flash_tick_gen.sv
module flash_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    // A divide of zero behaves as one: a tick on every cycle
    assign limit = (div == '0) ? '0 : div - 1'b1;
    assign tick  = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_cmd_pkg::*;
#(
    parameter int WR_TICKS   = 8,
    parameter int PAGE_TICKS = 40,
    parameter int MASS_TICKS = 100
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  fa_op_e start_op,
    input  logic   tick,
    output fa_op_e op_q,
    output logic   finish
);
    localparam int MAX_AB = (WR_TICKS > PAGE_TICKS) ? WR_TICKS : PAGE_TICKS;
    localparam int MAX_T  = (MAX_AB > MASS_TICKS) ? MAX_AB : MASS_TICKS;
    localparam int CW     = $clog2(MAX_T + 1);

    logic [CW-1:0] remain;

    function automatic logic [CW-1:0] ticks_for(input fa_op_e op);
        case (op)
            OP_PROG: ticks_for = CW'(WR_TICKS);
            OP_PAGE: ticks_for = CW'(PAGE_TICKS);
            OP_MASS: ticks_for = CW'(MASS_TICKS);
            default: ticks_for = CW'(1);
        endcase
    endfunction

    assign finish = (op_q != OP_IDLE) && tick && (remain <= CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            remain <= '0;
        end else if (op_q == OP_IDLE) begin
            if (start) begin
                op_q   <= start_op;
                remain <= ticks_for(start_op);
            end
        end else if (tick) begin
            if (remain <= CW'(1)) op_q <= OP_IDLE;
            else                  remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/flash_irq_unit.sv
module flash_irq_unit (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_done,
    input  logic       set_fail,
    input  logic       wr,
    input  logic [1:0] wr_clear,
    input  logic [1:0] wr_enable,
    output logic [1:0] flags,
    output logic [1:0] en,
    output logic       irq
);
    logic [1:0] clr;

    assign clr = wr ? wr_clear : 2'b00;
    assign irq = |(flags & en);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= 2'b00;
            en    <= 2'b00;
        end else begin
            if (wr) en <= wr_enable;
            // a new event wins over a clear in the same cycle
            flags <= (flags & ~clr) | {set_fail, set_done};
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int DIV_RESET  = 1,
    parameter int WR_TICKS   = 8,
    parameter int PAGE_TICKS = 40,
    parameter int MASS_TICKS = 100
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_we,
    input  logic [7:0]                  reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    output logic [1:0]                  fa_cmd,
    output logic [31:0]                 fa_addr,
    output logic [WORD_W*NUM_WORDS-1:0] fa_wdata,
    output logic [NUM_WORDS-1:0]        fa_wmask,
    output logic                        irq
);
    logic [31:0]                          addr_q;
    logic [DIV_W-1:0]                     div_q;
    ctl_cfg_t                             cfg_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0]     data_q;
    fa_op_e                               op_q;
    cmd_req_t                             req;
    logic                                 busy, ctl_wr, irq_wr, start, fail_set, op_done, tick;
    logic                                 cfg_we, data_hit;
    logic [1:0]                           irq_flags, irq_en;

    assign busy     = (op_q != OP_IDLE);
    assign req      = judge_cmd(reg_wdata);
    assign ctl_wr   = reg_we && (reg_addr == OFF_CTL);
    assign irq_wr   = reg_we && (reg_addr == OFF_IRQ);
    assign cfg_we   = reg_we && !busy;
    assign start    = ctl_wr && !busy && req.req && req.legal;
    assign fail_set = ctl_wr && req.req && (busy || !req.legal);
    assign data_hit = (reg_addr[7:4] == OFF_DATA0[7:4]) && (reg_addr[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            div_q  <= DIV_W'(DIV_RESET);
            cfg_q  <= '0;
        end else if (cfg_we) begin
            case (reg_addr)
                OFF_ADDR: addr_q <= reg_wdata;
                OFF_DIV:  div_q  <= reg_wdata[DIV_W-1:0];
                OFF_CTL:  cfg_q  <= cfg_from_word(reg_wdata);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (cfg_we && data_hit) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (reg_addr[LANE_W+1:2] == LANE_W'(i)) data_q[i] <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (data_hit) begin
            reg_rdata = data_q[reg_addr[LANE_W+1:2]];
        end else begin
            case (reg_addr)
                OFF_ADDR: reg_rdata = addr_q;
                OFF_DIV:  reg_rdata = 32'(div_q);
                OFF_CTL:  reg_rdata = ctl_word(cfg_q, op_q);
                OFF_IRQ:  reg_rdata = {22'b0, irq_en, 6'b0, irq_flags};
                default:  reg_rdata = '0;
            endcase
        end
    end

    flash_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .div     (div_q),
        .tick    (tick)
    );

    flash_op_seq #(
        .WR_TICKS   (WR_TICKS),
        .PAGE_TICKS (PAGE_TICKS),
        .MASS_TICKS (MASS_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .start_op (req.op),
        .tick     (tick),
        .op_q     (op_q),
        .finish   (op_done)
    );

    flash_irq_unit u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_done  (op_done),
        .set_fail  (fail_set),
        .wr        (irq_wr),
        .wr_clear  (reg_wdata[1:0]),
        .wr_enable (reg_wdata[9:8]),
        .flags     (irq_flags),
        .en        (irq_en),
        .irq       (irq)
    );

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_lane
            assign fa_wdata[w*WORD_W +: WORD_W] = data_q[w];
        end
    endgenerate

    assign fa_cmd   = op_q;
    assign fa_addr  = addr_q;
    assign fa_wmask = (op_q == OP_PROG) ? lane_mask(cfg_q.narrow, addr_q[LANE_W+1:2]) : '0;

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
    import flash_cmd_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_we,
    input logic [7:0]           reg_addr,
    input logic [3:0]           ctl_key,
    input logic [2:0]           ctl_cmd,
    input logic [1:0]           fa_cmd,
    input logic [31:0]          fa_addr,
    input logic [NUM_WORDS-1:0] fa_wmask,
    input logic                 irq,
    input logic                 fail_flag,
    input logic [1:0]           irq_en
);
    // R5: a command with a wrong key is flagged on the next cycle
    assert_fail_on_bad_key_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFF_CTL && ctl_cmd != 3'b000 && ctl_key != KEY_OPEN) |=> fail_flag);

    // R3: an operation leaves idle only after a control write
    assert_start_from_ctl_R3: assert property (@(posedge clk) disable iff (rst)
        (fa_cmd != OP_IDLE && $past(fa_cmd) == OP_IDLE) |-> ($past(reg_we) && $past(reg_addr) == OFF_CTL));

    // R6: a running command never changes into another one
    assert_op_held_R6: assert property (@(posedge clk) disable iff (rst)
        (fa_cmd != OP_IDLE) |=> (fa_cmd == OP_IDLE || fa_cmd == $past(fa_cmd)));

    // R11: the target address is frozen while busy
    assert_addr_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        (fa_cmd != OP_IDLE) |=> (fa_cmd == OP_IDLE || $stable(fa_addr)));

    // R7: a program drives either all lanes or exactly one
    assert_mask_shape_R7: assert property (@(posedge clk) disable iff (rst)
        (fa_cmd == OP_PROG) |-> (fa_wmask == '1 || $onehot(fa_wmask)));

    // R9: with both enables off the line stays low
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_en == 2'b00) |-> !irq);
endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .ctl_key   (reg_wdata[31:28]),
    .ctl_cmd   (reg_wdata[2:0]),
    .fa_cmd    (fa_cmd),
    .fa_addr   (fa_addr),
    .fa_wmask  (fa_wmask),
    .irq       (irq),
    .fail_flag (irq_flags[1]),
    .irq_en    (irq_en)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
    localparam int WR_T = 8, PG_T = 40, MS_T = 100, DIV_RST = 1;
    localparam logic [7:0] A_ADDR = 8'h00, A_DIV = 8'h04, A_CTL = 8'h08, A_IRQ = 8'h24, A_D0 = 8'h30;

    logic         clk = 1'b0, rst = 1'b1, reg_we = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0, reg_rdata;
    logic [1:0]   fa_cmd;
    logic [31:0]  fa_addr;
    logic [127:0] fa_wdata;
    logic [3:0]   fa_wmask;
    logic         irq;
    int checks = 0, errors = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    flash_cmd_ctrl #(.DIV_RESET(DIV_RST), .WR_TICKS(WR_T), .PAGE_TICKS(PG_T), .MASS_TICKS(MS_T)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fa_cmd(fa_cmd), .fa_addr(fa_addr), .fa_wdata(fa_wdata),
        .fa_wmask(fa_wmask), .irq(irq));

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (fa_cmd != 2'd0 && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic int exp_op(input logic [31:0] w);
        case (w[2:0])
            3'b001: return 1;
            3'b100: return 2;
            3'b010: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_legal(input logic [31:0] w);
        int op = exp_op(w);
        if (op == 0 || w[31:28] != 4'h2) return 0;
        if (op == 2) return w[15:8] == 8'h55;
        if (op == 3) return w[15:8] == 8'hAA;
        return 1;
    endfunction

    function automatic int exp_ticks(input int op);
        return (op == 1) ? WR_T : (op == 2) ? PG_T : MS_T;
    endfunction

    function automatic logic [3:0] exp_mask(input int op, input logic narrow, input logic [31:0] a);
        if (op != 1) return 4'h0;
        return narrow ? (4'h1 << a[3:2]) : 4'hF;
    endfunction

    task automatic run_cmd(input string tag, input logic [31:0] w, input int dv, input logic [31:0] a);
        logic [31:0] v;
        int n, op;
        op = exp_op(w);
        wr(A_ADDR, a);
        wr(A_DIV, dv);
        wr(A_CTL, w);
        if (exp_legal(w)) begin
            check({tag, " command code"}, fa_cmd, op);
            check({tag, " R7 lane mask"}, fa_wmask, exp_mask(op, w[4], a));
            check({tag, " R7 address"}, fa_addr, a);
            wait_idle(n);
            check({tag, " duration"}, n, exp_ticks(op) * ((dv == 0) ? 1 : dv));
            rd(A_IRQ, v);
            check({tag, " done flag"}, v[1:0], 2'b01);
            rd(A_CTL, v);
            check({tag, " R3 command bits cleared"}, {v[24], v[2:0]}, 4'h0);
        end else begin
            check({tag, " R5 no operation"}, fa_cmd, 2'd0);
            rd(A_IRQ, v);
            check({tag, " R5 access fail"}, v[1:0], 2'b10);
        end
        wr(A_IRQ, 32'h3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, x, w;
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_ADDR, v); check("R1 address", v, 0);
        rd(A_DIV, v);  check("R1 divide", v, DIV_RST);
        rd(A_CTL, v);  check("R1 control", v, 0);
        rd(A_IRQ, v);  check("R1 interrupt", v, 0);
        rd(A_D0 + 8'hC, v); check("R1 data3", v, 0);
        check("R1 fa_cmd", fa_cmd, 0);
        check("R1 irq", irq, 0);

        // R2 random register read/write
        for (int i = 0; i < 12; i++) begin
            logic [7:0] a;
            a = A_D0 + 8'(4 * (i % 4));
            x = $urandom;
            wr(a, x); rd(a, v); check("R2 data word", v, x);
            x = $urandom;
            wr(A_ADDR, x); rd(A_ADDR, v); check("R2 address", v, x);
            x = $urandom;
            wr(A_DIV, x); rd(A_DIV, v); check("R2 divide 8 bits", v, {24'h0, x[7:0]});
            x = $urandom & 32'hFFFF_FFF8;
            wr(A_CTL, x); rd(A_CTL, v); check("R2 control fields", v, x & 32'hFA00_FF10);
        end
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); check("R2 unmapped reads 0", v, 0);
        wr(A_IRQ, 32'h3);

        // R3 / R7 directed programs
        for (int k = 0; k < 4; k++) wr(A_D0 + 8'(4 * k), 32'h1111_0000 * (k + 1));
        run_cmd("R3 program 128", 32'h2000_0001, 2, 32'h0000_1230);
        check("R7 data bus", fa_wdata, {32'h4444_0000, 32'h3333_0000, 32'h2222_0000, 32'h1111_0000});
        run_cmd("R3 program 32", 32'h2000_0011, 3, 32'h0000_4568);
        run_cmd("R10 divide zero", 32'h2000_0011, 0, 32'h0000_000C);
        run_cmd("R4 page erase", 32'h2000_5504, 2, 32'h0000_8000);
        run_cmd("R4 mass erase", 32'h2000_AA02, 1, 32'h0);

        // R5 refused commands
        run_cmd("R5 locked key", 32'h3000_0001, 1, 32'h0);
        run_cmd("R5 page wrong code", 32'h2000_AA04, 1, 32'h0);
        run_cmd("R5 mass wrong code", 32'h2000_5502, 1, 32'h0);
        run_cmd("R5 two commands", 32'h2000_AA03, 1, 32'h0);
        rd(A_IRQ, v); check("R8 flags cleared", v[1:0], 2'b00);

        // R6 / R11 command while busy
        wr(A_D0, 32'hCAFE_0001);
        wr(A_ADDR, 32'h0000_0400);
        wr(A_DIV, 1);
        wr(A_CTL, 32'h2000_AA02);
        check("R4 mass running", fa_cmd, 3);
        rd(A_CTL, v); check("R3 busy bit", {v[24], v[1]}, 2'b11);
        wr(A_CTL, 32'h2000_5504);
        check("R6 still mass", fa_cmd, 3);
        rd(A_IRQ, v); check("R6 access fail", v[1:0], 2'b10);
        rd(A_CTL, v); check("R6 control unchanged", v[15:8], 8'hAA);
        wr(A_D0, 32'hDEAD_0002);
        rd(A_D0, v); check("R11 data frozen", v, 32'hCAFE_0001);
        wr(A_ADDR, 32'h0000_0800);
        check("R11 address frozen", fa_addr, 32'h0000_0400);
        wait_idle(n);
        rd(A_IRQ, v); check("R6 done after", v[1:0], 2'b11);
        wr(A_IRQ, 32'h3);

        // R8 / R9 interrupt line
        wr(A_IRQ, 32'h100);
        check("R9 no flag low", irq, 0);
        wr(A_CTL, 32'h2000_0001);
        wait_idle(n);
        @(negedge clk);
        check("R9 done enabled", irq, 1);
        wr(A_IRQ, 32'h200);
        check("R9 done masked", irq, 0);
        rd(A_IRQ, v); check("R8 write 0 keeps flag", v, 32'h201);
        wr(A_CTL, 32'h3000_0001);
        @(negedge clk);
        check("R9 fail enabled", irq, 1);
        wr(A_IRQ, 32'h202);
        check("R8 fail cleared", irq, 0);
        rd(A_IRQ, v); check("R8 done kept", v, 32'h201);
        wr(A_IRQ, 32'h1);
        rd(A_IRQ, v); check("R8 all clear", v, 0);

        // random commands, legal and not
        for (int i = 0; i < 30; i++) begin
            logic [3:0] key;
            logic [7:0] code;
            logic [2:0] cb;
            int pick;
            pick = $urandom % 4;
            key  = (pick == 0) ? 4'h3 : (pick == 1) ? 4'($urandom) : 4'h2;
            pick = $urandom % 4;
            code = (pick == 0) ? 8'h55 : (pick == 1) ? 8'hAA : (pick == 2) ? 8'h00 : 8'($urandom);
            pick = $urandom % 5;
            cb   = (pick == 0) ? 3'b001 : (pick == 1) ? 3'b010 : (pick == 2) ? 3'b100 : (pick == 3) ? 3'b110 : 3'b001;
            w = {key, 4'($urandom) & 4'hA, 8'h0, code, 3'b0, 1'($urandom), 1'b0, cb};
            run_cmd("R4 random", w, int'($urandom % 4), $urandom);
        end

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule